// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block recovers an I2C bus on which a target device has been left driving SDA low, for example after a controller reset in the middle of a read. On a start request it takes control of both lines as an open-drain driver. It only ever pulls a line low or lets it go, and never drives a line high. It toggles SCL until the target lets go of SDA or a pulse budget is spent. It then always finishes by generating a STOP condition, so that every target on the bus returns to idle.

After each clock pulse the sequencer checks whether SDA has gone high, and stops pulsing at the first SDA-high sample. The recovery therefore stops on the target's acknowledge slot or on a 1 data bit, and no further bits are clocked out blindly. Half-period timing comes from a cycle counter. A parameter gives the number of system clocks per SCL half period. The default of 250 clocks at 50 MHz gives 5 µs, which is standard-mode timing. When the sequence ends, a one-cycle done pulse is issued. A stuck flag goes high with done if SDA was still low when the pulse budget ran out.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is asserted and whenever the block is idle, both line enables (`scl_pull`, `sda_pull`; 1 means pull the line low) are 0, and `busy`, `done` and `stuck` are 0.
- R2: A `start` sampled high while idle makes `busy` high from the next cycle. The block then pulls SCL low with SDA released for exactly HALF_CYCLES cycles.
- R3: Each recovery pulse releases SCL for HALF_CYCLES cycles and then pulls it low for HALF_CYCLES cycles. SDA stays released for the whole pulse.
- R4: SDA is sampled in the last cycle of every SCL-low half period. Another pulse follows only if that sample is low and fewer than MAX_PULSES pulses have been issued. A target that holds SDA through K rising SCL edges therefore receives min(K, MAX_PULSES) pulses.
- R5: The STOP phase pulls SDA low with SCL still low for HALF_CYCLES cycles. It then releases SCL for HALF_CYCLES cycles with SDA still low, and finally releases SDA. SDA is only ever pulled low while SCL is held low.
- R6: `done` is high for exactly one cycle, in the first cycle after the STOP in which both lines are released. `busy` is low in that same cycle.
- R7: `stuck` is high together with `done` exactly when the final SDA sample before the STOP was low with the pulse budget used up. Otherwise `stuck` stays low.
- R8: A `start` that arrives while `busy` is high has no effect on the sequence in progress.
- R9: No more than MAX_PULSES SCL releases occur before the STOP phase of one sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a bus-clear sequence |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| stuck | output | 1 | With done: SDA was never seen released |

## Verification
A request accepted at a clock edge shows up on the outputs in the cycle right after that edge. From then on, every line change falls exactly HALF_CYCLES cycles after the previous one. `done` and `stuck` appear one cycle after the last STOP half period ends. The bench holds a queue of expected output vectors for each accepted request. It builds that queue from the number of rising SCL edges the modelled target needs. It pops and compares one vector at every falling clock edge, so every result is checked in the exact cycle it is due. Targets that release at once, partway through, exactly at the budget and never are all exercised. So are repeated requests while busy and a request in the done cycle itself.

// File: rtl/i2c_clr_pkg.sv
package i2c_clr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_PREP     = 3'd1,
        PH_PULSE_HI = 3'd2,
        PH_PULSE_LO = 3'd3,
        PH_STOP_LO  = 3'd4,
        PH_STOP_HI  = 3'd5
    } clr_phase_e;

    typedef struct packed {
        clr_phase_e phase;
        logic       held_low;
        logic       done;
        logic       stuck;
    } clr_ctl_s;

endpackage

// File: rtl/clr_half_timer.sv
module clr_half_timer #(
    parameter int HALF_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(HALF_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(HALF_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/clr_pulse_counter.sv
module clr_pulse_counter #(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_PULSES + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (incr && !at_limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == PW'(MAX_PULSES));

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import i2c_clr_pkg::*;
#(
    parameter int HALF_CYCLES = 250,
    parameter int MAX_PULSES  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done,
    output logic stuck
);
    clr_ctl_s ctl_d, ctl_q;
    logic     tmr_load;
    logic     tmr_expire;
    logic     cnt_clear;
    logic     cnt_incr;
    logic     cnt_at_limit;

    clr_half_timer #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .expire(tmr_expire)
    );

    clr_pulse_counter #(
        .MAX_PULSES(MAX_PULSES)
    ) u_pulses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .incr    (cnt_incr),
        .at_limit(cnt_at_limit)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.stuck = 1'b0;
        tmr_load    = 1'b0;
        cnt_clear   = 1'b0;
        cnt_incr    = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.phase    = PH_PREP;
                    ctl_d.held_low = 1'b0;
                    tmr_load       = 1'b1;
                    cnt_clear      = 1'b1;
                end
            end
            PH_PREP, PH_PULSE_LO: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    if (!sda_in && !cnt_at_limit) begin
                        ctl_d.phase = PH_PULSE_HI;
                        cnt_incr    = 1'b1;
                    end else begin
                        ctl_d.phase    = PH_STOP_LO;
                        ctl_d.held_low = !sda_in;
                    end
                end
            end
            PH_PULSE_HI: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_PULSE_LO;
                    tmr_load    = 1'b1;
                end
            end
            PH_STOP_LO: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_STOP_HI;
                    tmr_load    = 1'b1;
                end
            end
            PH_STOP_HI: begin
                if (tmr_expire) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.stuck = ctl_q.held_low;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, held_low: 1'b0, done: 1'b0, stuck: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_pull = (ctl_q.phase == PH_PREP) || (ctl_q.phase == PH_PULSE_LO)
                   || (ctl_q.phase == PH_STOP_LO);
    assign sda_pull = (ctl_q.phase == PH_STOP_LO) || (ctl_q.phase == PH_STOP_HI);
    assign busy     = (ctl_q.phase != PH_IDLE);
    assign done     = ctl_q.done;
    assign stuck    = ctl_q.stuck;

endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic done,
    input logic stuck
);
    localparam int RW = $clog2(MAX_PULSES + 2);

    logic [RW-1:0] rel_cnt;
    logic          scl_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_cnt  <= '0;
            scl_prev <= 1'b0;
        end else begin
            scl_prev <= scl_pull;
            if (!busy) begin
                rel_cnt <= '0;
            end else if (scl_prev && !scl_pull && !sda_pull) begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull)); // R1
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && scl_pull && !sda_pull)); // R2
    AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt <= RW'(MAX_PULSES)); // R9
    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull); // R5
    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> (done && !scl_pull)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_STUCK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |-> done); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && start) |=> (busy || done)); // R8

endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(
    .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .scl_pull(scl_pull),
    .sda_pull(sda_pull),
    .busy    (busy),
    .done    (done),
    .stuck   (stuck)
);

// File: tb/i2c_bus_clear_tb.sv
module i2c_bus_clear_tb;
    localparam int HALF = 4;
    localparam int MAXP = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sda_in;
    logic scl_pull, sda_pull, busy, done, stuck;

    always #10 clk = ~clk;

    int  tgt_left = 0;
    logic scl_prev = 1'b0;
    logic [4:0] expq[$];
    int checks = 0;
    int fails = 0;

    assign sda_in = !sda_pull && (tgt_left == 0);

    i2c_bus_clear #(
        .HALF_CYCLES(HALF),
        .MAX_PULSES (MAXP)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sda_in  (sda_in),
        .scl_pull(scl_pull),
        .sda_pull(sda_pull),
        .busy    (busy),
        .done    (done),
        .stuck   (stuck)
    );

    // Vector order: busy, scl_pull, sda_pull, done, stuck
    function automatic void plan(int k);
        int p;
        p = (k < MAXP) ? k : MAXP;
        for (int i = 0; i < HALF; i++) expq.push_back(5'b11000);
        for (int n = 0; n < p; n++) begin
            for (int i = 0; i < HALF; i++) expq.push_back(5'b10000);
            for (int i = 0; i < HALF; i++) expq.push_back(5'b11000);
        end
        for (int i = 0; i < HALF; i++) expq.push_back(5'b11100);
        for (int i = 0; i < HALF; i++) expq.push_back(5'b10100);
        expq.push_back({4'b0001, (k > MAXP)});
    endfunction

    task automatic step(input logic st, input string tag);
        logic [4:0] exp_v, got_v;
        @(negedge clk);
        exp_v = (expq.size() > 0) ? expq.pop_front() : 5'b00000;
        got_v = {busy, scl_pull, sda_pull, done, stuck};
        checks++;
        if (got_v !== exp_v) begin
            fails++;
            $display("FAIL %s: got %b expected %b (busy,scl,sda,done,stuck) at %0t",
                     tag, got_v, exp_v, $time);
        end
        if (scl_prev && !scl_pull && tgt_left > 0) tgt_left--;
        scl_prev = scl_pull;
        start = st;
        if (st && rst_n && expq.size() == 0) plan(tgt_left);
    endtask

    task automatic run(input int k, input string tag);
        tgt_left = k;
        step(1'b1, tag);
        step(1'b0, tag);
        while (expq.size() > 0) step(1'b0, tag);
        step(1'b0, tag);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, even with start pulled high
        for (int i = 0; i < 4; i++) step(1'b1, "R1 reset");
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, "R1 idle");

        // R2 R5 R6: target already released, no pulses
        run(0, "R2 R5 R6 no pulse");
        // R3 R4: partial holds
        run(1, "R3 R4 one pulse");
        run(3, "R3 R4 three pulses");
        // R4 R7: release exactly at budget
        run(MAXP, "R4 R7 at budget");
        // R7 R9: never released
        run(MAXP + 1, "R7 R9 stuck by one");
        run(40, "R7 R9 stuck hard");

        // R8: start held high throughout a sequence
        tgt_left = 2;
        step(1'b1, "R8 start");
        for (int i = 0; i < 6 * HALF; i++) step(1'b1, "R8 ignored while busy");
        // The next start is accepted in the done cycle (back-to-back)
        while (expq.size() > 1) step(1'b0, "R8 drain");
        tgt_left = 1;
        step(1'b1, "R6 restart on done");
        while (expq.size() > 0) step(1'b0, "R6 R2 back-to-back");
        for (int i = 0; i < 3; i++) step(1'b0, "R1 idle after");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule